// File: doc/BRIEF.md
# Floppy Controller Command Front-End

This block is the register-level front end of a PC-style floppy disk controller. A host CPU reaches it through three byte-wide addresses, each with its own select strobe. The first is a drive-control register that holds four motor enables, a DMA enable, a run/hold bit and a two-bit drive select. The second is a read-only main status byte. The third is a data port: command and parameter bytes are written to it, and result bytes are read back from it.

A small state machine sequences every command. It has five states. ST_HELD is the controller held in reset. ST_IDLE waits for an opcode byte. ST_PARAM collects parameter bytes. ST_EXEC is a single cycle in which the command takes effect. ST_RESULT drains the result queue.

The transitions are as follows:
- Reset, or clearing the run bit, enters ST_HELD.
- Setting the run bit from 0 to 1 moves ST_HELD to ST_IDLE.
- An opcode with parameters moves ST_IDLE to ST_PARAM.
- An opcode without parameters, or the final parameter byte, moves to ST_EXEC.
- ST_EXEC goes to ST_RESULT when the command produced result bytes, and to ST_IDLE when it did not.
- Reading the last result byte returns to ST_IDLE.

A drive table keeps, for each drive, a track number, a status byte (ST0) and a pending-interrupt flag, and it drives one interrupt request line. The table serves the seek, recalibrate, sense-interrupt, specify and invalid commands. Head stepping takes no time, and no sector data moves.

Top module: `floppy_cmd_front`

## Requirements
- R1: The drive-control register reads back as written. `motor_on[i]` equals bit 4+i (i = 0..3), `dma_on` equals bit 3, bit 2 is run (1) / hold (0), and `drv_sel` equals bits 1..0.
- R2: While bit 2 of the drive-control register is 0, the following hold:
  - `irq_o` is low.
  - The main status reads 0x00.
  - Data port writes are ignored.
- R3: A write that takes bit 2 from 0 to 1 does the following:
  - It clears the command collector.
  - It marks all four drives pending with ST0 = 0xC0 | drive.
  - It raises `irq_o`.
  - The main status reads 0x80.
- R4: Seek has opcode low five bits 0x0F and two parameters. Parameter 1 carries the head in bit 2 and the drive in bits 1..0; parameter 2 is the cylinder. Seek sets that drive's track to the cylinder and its ST0 to 0x20 | head<<2 | drive. It marks the drive pending, raises `irq_o` and returns no result bytes.
- R5: Recalibrate has opcode 0x07 and one parameter, with the drive in bits 1..0. It sets the track to 0 and ST0 to 0x20 | drive, marks the drive pending and raises `irq_o`.
- R6: Sense interrupt status has opcode 0x08 and no parameters.
  - For each pending drive, in ascending drive order, it queues ST0 and then the track. It then clears every pending flag and drops `irq_o`.
  - With no drive pending, it returns the single byte 0x80.
- R7: The main status uses bit 7 = ready, bit 6 = direction to CPU and bit 4 = busy. It reads 0x80 when waiting for an opcode, 0x90 while collecting parameters and 0xD0 while results wait. Reading the last result byte returns it to 0x80.
- R8: A data port read while no results wait returns 0x80 and changes nothing.
- R9: Specify has opcode 0x03 and two parameters. It places parameter 1 on `cfg_a` and parameter 2 on `cfg_b`, returns no result bytes and leaves `irq_o` unchanged.
- R10: Only the low five opcode bits are decoded. Any opcode other than the four above takes no parameters and returns the single byte 0x80.
- R11: Data port writes made while results wait are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dor_sel | input | 1 | Selects the drive-control register |
| msr_sel | input | 1 | Selects the main status byte |
| dat_sel | input | 1 | Selects the command/data port |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe (pops a result byte) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected address |
| irq_o | output | 1 | Interrupt request |
| motor_on | output | 4 | Motor enables for drives 3..0 |
| dma_on | output | 1 | DMA enable |
| drv_sel | output | 2 | Selected drive |
| cfg_a | output | 8 | First stored specify parameter |
| cfg_b | output | 8 | Second stored specify parameter |

## Verification
Seek is swept over every drive, both heads and several cylinders, including 0 and 255. Opcodes with and without high bits are used, so that a wrong ST0 field or a decode of the upper bits shows up. All 32 low-five-bit opcodes are tried, which separates the four real commands from the invalid path. Seeks to two drives before one sense show whether results come out in ascending drive order. Releasing hold after seeks proves that pending flags, ST0 and irq are re-marked while tracks are kept. Writes made while held, and writes made while results wait, prove that those bytes are dropped.

// File: rtl/fcf_pkg.sv
package fcf_pkg;

    typedef enum logic [2:0] {
        ST_HELD,
        ST_IDLE,
        ST_PARAM,
        ST_EXEC,
        ST_RESULT
    } fsm_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_SPEC,
        K_RECAL,
        K_SENSE,
        K_SEEK,
        K_INV
    } kind_e;

    localparam logic [4:0] OPC_SPEC  = 5'h03;
    localparam logic [4:0] OPC_RECAL = 5'h07;
    localparam logic [4:0] OPC_SENSE = 5'h08;
    localparam logic [4:0] OPC_SEEK  = 5'h0F;

    localparam int MSR_RQM  = 7;
    localparam int MSR_DIO  = 6;
    localparam int MSR_BUSY = 4;

    localparam logic [7:0] ST0_SEEK_END = 8'h20;
    localparam logic [7:0] ST0_NOT_RDY  = 8'hC0;
    localparam logic [7:0] BYTE_INVALID = 8'h80;

    function automatic kind_e kind_of(input logic [4:0] op);
        case (op)
            OPC_SPEC:  return K_SPEC;
            OPC_RECAL: return K_RECAL;
            OPC_SENSE: return K_SENSE;
            OPC_SEEK:  return K_SEEK;
            default:   return K_INV;
        endcase
    endfunction

    function automatic logic [1:0] nparams(input kind_e k);
        case (k)
            K_SPEC:  return 2'd2;
            K_SEEK:  return 2'd2;
            K_RECAL: return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/fcf_dor_reg.sv
module fcf_dor_reg (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] dor_q,
    output logic       hold_p,
    output logic       release_p
);
    always_ff @(posedge clk) begin
        if (rst)
            dor_q <= 8'h00;
        else if (wr)
            dor_q <= wdata;
    end

    assign hold_p    = wr & ~wdata[2];
    assign release_p = wr & wdata[2] & ~dor_q[2];
endmodule

// File: rtl/fcf_cmd_fsm.sv
module fcf_cmd_fsm
    import fcf_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold_p,
    input  logic          release_p,
    input  logic          dwr,
    input  logic          drd,
    input  logic [7:0]    wdata,
    input  logic [CW-1:0] res_cnt,
    input  logic          q_last,
    output fsm_e          state,
    output kind_e         kind,
    output logic [7:0]    p0,
    output logic [7:0]    p1,
    output logic [7:0]    msr
);
    fsm_e       nxt;
    logic [1:0] pcnt;
    logic [1:0] need;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HELD:   if (release_p) nxt = ST_IDLE;
            ST_IDLE:   if (dwr) nxt = (nparams(kind_of(wdata[4:0])) == 2'd0) ? ST_EXEC : ST_PARAM;
            ST_PARAM:  if (dwr && (pcnt + 2'd1) == need) nxt = ST_EXEC;
            ST_EXEC:   nxt = (res_cnt != '0) ? ST_RESULT : ST_IDLE;
            ST_RESULT: if (drd && q_last) nxt = ST_IDLE;
            default:   nxt = ST_HELD;
        endcase
        if (hold_p) nxt = ST_HELD;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_HELD;
        else
            state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind <= K_NONE;
            need <= 2'd0;
            pcnt <= 2'd0;
            p0   <= 8'h00;
            p1   <= 8'h00;
        end else if (hold_p || state == ST_HELD) begin
            kind <= K_NONE;
            pcnt <= 2'd0;
        end else if (state == ST_IDLE && dwr) begin
            kind <= kind_of(wdata[4:0]);
            need <= nparams(kind_of(wdata[4:0]));
            pcnt <= 2'd0;
        end else if (state == ST_PARAM && dwr) begin
            if (pcnt == 2'd0) p0 <= wdata;
            else              p1 <= wdata;
            pcnt <= pcnt + 2'd1;
        end
    end

    always_comb begin
        msr = 8'h00;
        unique case (state)
            ST_HELD:   msr = 8'h00;
            ST_IDLE:   msr[MSR_RQM] = 1'b1;
            ST_PARAM:  begin msr[MSR_RQM] = 1'b1; msr[MSR_BUSY] = 1'b1; end
            ST_EXEC:   msr[MSR_BUSY] = 1'b1;
            ST_RESULT: begin msr[MSR_RQM] = 1'b1; msr[MSR_DIO] = 1'b1; msr[MSR_BUSY] = 1'b1; end
            default:   msr = 8'h00;
        endcase
    end
endmodule

// File: rtl/fcf_drive_table.sv
module fcf_drive_table
    import fcf_pkg::*;
#(
    parameter int NDRV = 4,
    parameter int QD   = 2 * NDRV,
    parameter int CW   = $clog2(QD + 1),
    parameter int PW   = $clog2(QD)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hold_p,
    input  logic                 release_p,
    input  logic                 exec,
    input  kind_e                kind,
    input  logic [7:0]           p0,
    input  logic [7:0]           p1,
    output logic                 irq,
    output logic [CW-1:0]        res_cnt,
    output logic [QD-1:0][7:0]   res_bytes,
    output logic [7:0]           cfg_a,
    output logic [7:0]           cfg_b
);
    localparam int DW = (NDRV > 1) ? $clog2(NDRV) : 1;

    logic [7:0]      track [NDRV];
    logic [7:0]      st0   [NDRV];
    logic [NDRV-1:0] pend;
    logic [PW-1:0]   pos;
    logic [DW-1:0]   dsel;

    assign dsel = p0[DW-1:0];

    always_comb begin
        res_cnt   = '0;
        res_bytes = '0;
        pos       = '0;
        if (kind == K_INV || (kind == K_SENSE && pend == '0)) begin
            res_cnt      = CW'(1);
            res_bytes[0] = BYTE_INVALID;
        end else if (kind == K_SENSE) begin
            for (int d = 0; d < NDRV; d++) begin
                if (pend[d]) begin
                    res_bytes[pos]          = st0[d];
                    res_bytes[pos + PW'(1)] = track[d];
                    pos     = pos + PW'(2);
                    res_cnt = res_cnt + CW'(2);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq   <= 1'b0;
            pend  <= '0;
            cfg_a <= 8'h00;
            cfg_b <= 8'h00;
            for (int d = 0; d < NDRV; d++) begin
                track[d] <= 8'h00;
                st0[d]   <= 8'h00;
            end
        end else if (hold_p) begin
            irq <= 1'b0;
        end else if (release_p) begin
            irq  <= 1'b1;
            pend <= '1;
            for (int d = 0; d < NDRV; d++)
                st0[d] <= ST0_NOT_RDY | 8'(d);
        end else if (exec) begin
            case (kind)
                K_SEEK: begin
                    track[dsel] <= p1;
                    st0[dsel]   <= ST0_SEEK_END | {5'b0, p0[2:0]};
                    pend[dsel]  <= 1'b1;
                    irq         <= 1'b1;
                end
                K_RECAL: begin
                    track[dsel] <= 8'h00;
                    st0[dsel]   <= ST0_SEEK_END | {{(8-DW){1'b0}}, dsel};
                    pend[dsel]  <= 1'b1;
                    irq         <= 1'b1;
                end
                K_SENSE: begin
                    pend <= '0;
                    irq  <= 1'b0;
                end
                K_SPEC: begin
                    cfg_a <= p0;
                    cfg_b <= p1;
                end
                default: ;
            endcase
        end
    end

    // R4
    seek_raises_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (exec && kind == K_SEEK && !hold_p) |=> irq);

    // R6
    sense_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (exec && kind == K_SENSE && !hold_p) |=> !irq);
endmodule

// File: rtl/fcf_result_queue.sv
module fcf_result_queue #(
    parameter int QD = 8,
    parameter int CW = $clog2(QD + 1),
    parameter int PW = $clog2(QD)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               load,
    input  logic [CW-1:0]      load_cnt,
    input  logic [QD-1:0][7:0] load_bytes,
    input  logic               pop,
    output logic [7:0]         head,
    output logic               empty,
    output logic               last
);
    logic [QD-1:0][7:0] mem;
    logic [PW-1:0]      rdp;
    logic [CW-1:0]      lvl;

    always_ff @(posedge clk) begin
        if (load) mem <= load_bytes;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            lvl <= '0;
            rdp <= '0;
        end else if (load) begin
            lvl <= load_cnt;
            rdp <= '0;
        end else if (pop && lvl != '0) begin
            lvl <= lvl - CW'(1);
            rdp <= rdp + PW'(1);
        end
    end

    assign head  = mem[rdp];
    assign empty = (lvl == '0);
    assign last  = (lvl == CW'(1));

    // R6
    queue_bound_chk: assert property (@(posedge clk) disable iff (rst)
        lvl <= CW'(QD));
endmodule

// File: rtl/floppy_cmd_front.sv
module floppy_cmd_front
    import fcf_pkg::*;
#(
    parameter int NDRV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dor_sel,
    input  logic       msr_sel,
    input  logic       dat_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq_o,
    output logic [3:0] motor_on,
    output logic       dma_on,
    output logic [1:0] drv_sel,
    output logic [7:0] cfg_a,
    output logic [7:0] cfg_b
);
    localparam int QD = 2 * NDRV;
    localparam int CW = $clog2(QD + 1);
    localparam int PW = $clog2(QD);

    logic [7:0]         dor_q;
    logic               hold_p, release_p;
    fsm_e               state;
    kind_e              kind;
    logic [7:0]         p0, p1, msr;
    logic [CW-1:0]      res_cnt;
    logic [QD-1:0][7:0] res_bytes;
    logic [7:0]         q_head;
    logic               q_empty, q_last;
    logic               dwr, drd, exec, q_load, q_pop;

    assign dwr    = dat_sel & wr_en;
    assign drd    = dat_sel & rd_en;
    assign exec   = (state == ST_EXEC);
    assign q_load = exec & (res_cnt != '0) & ~hold_p;
    assign q_pop  = drd & (state == ST_RESULT);

    fcf_dor_reg u_dor (
        .clk(clk), .rst(rst), .wr(dor_sel & wr_en), .wdata(wdata),
        .dor_q(dor_q), .hold_p(hold_p), .release_p(release_p)
    );

    fcf_cmd_fsm #(.CW(CW)) u_fsm (
        .clk(clk), .rst(rst), .hold_p(hold_p), .release_p(release_p),
        .dwr(dwr), .drd(drd), .wdata(wdata), .res_cnt(res_cnt), .q_last(q_last),
        .state(state), .kind(kind), .p0(p0), .p1(p1), .msr(msr)
    );

    fcf_drive_table #(.NDRV(NDRV), .QD(QD), .CW(CW), .PW(PW)) u_tab (
        .clk(clk), .rst(rst), .hold_p(hold_p), .release_p(release_p),
        .exec(exec), .kind(kind), .p0(p0), .p1(p1), .irq(irq_o),
        .res_cnt(res_cnt), .res_bytes(res_bytes), .cfg_a(cfg_a), .cfg_b(cfg_b)
    );

    fcf_result_queue #(.QD(QD), .CW(CW), .PW(PW)) u_q (
        .clk(clk), .rst(rst), .flush(hold_p), .load(q_load),
        .load_cnt(res_cnt), .load_bytes(res_bytes), .pop(q_pop),
        .head(q_head), .empty(q_empty), .last(q_last)
    );

    assign motor_on = dor_q[7:4];
    assign dma_on   = dor_q[3];
    assign drv_sel  = dor_q[1:0];

    always_comb begin
        if (dat_sel)
            rdata = (state == ST_RESULT) ? q_head : BYTE_INVALID;
        else if (msr_sel)
            rdata = msr;
        else if (dor_sel)
            rdata = dor_q;
        else
            rdata = 8'hFF;
    end

    // R2
    held_irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HELD) |-> !irq_o);

    // R3
    release_arms_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dor_q[2]) |-> (irq_o && state == ST_IDLE));

    // R7
    result_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RESULT) |-> !q_empty);

    // R7
    last_pop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (q_pop && q_last && !hold_p) |=> (state == ST_IDLE));
endmodule

// File: tb/floppy_cmd_front_bench.sv
module floppy_cmd_front_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dor_sel = 1'b0, msr_sel = 1'b0, dat_sel = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_o;
    logic [3:0] motor_on;
    logic       dma_on;
    logic [1:0] drv_sel;
    logic [7:0] cfg_a, cfg_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] trk [4];

    always #2 clk = ~clk;

    floppy_cmd_front u_floppy_cmd_front (
        .clk(clk), .rst(rst), .dor_sel(dor_sel), .msr_sel(msr_sel), .dat_sel(dat_sel),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
        .motor_on(motor_on), .dma_on(dma_on), .drv_sel(drv_sel), .cfg_a(cfg_a), .cfg_b(cfg_b)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pick(input int port);
        dor_sel = (port == 0);
        msr_sel = (port == 1);
        dat_sel = (port == 2);
    endtask

    task automatic wr(input int port, input logic [7:0] v);
        @(negedge clk);
        pick(port); wr_en = 1'b1; wdata = v;
        @(negedge clk);
        wr_en = 1'b0; pick(3);
        @(negedge clk);
    endtask

    task automatic rd(input int port, output logic [7:0] v);
        @(negedge clk);
        pick(port); rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0; pick(3);
    endtask

    task automatic peek(input int port, output logic [7:0] v);
        pick(port);
        #1 v = rdata;
        pick(3);
    endtask

    task automatic sense(input string tag, input int n, input logic [7:0] e [8]);
        logic [7:0] v;
        wr(2, 8'h08);
        peek(1, v); chk({tag, " msr results"}, v, 8'hD0);
        for (int i = 0; i < n; i++) begin
            rd(2, v); chk({tag, " byte"}, v, e[i]);
        end
        peek(1, v); chk({tag, " msr after"}, v, 8'h80);
        chk({tag, " irq low"}, {7'b0, irq_o}, 8'h00);
    endtask

    task automatic seek(input int d, input int h, input logic [7:0] c, input logic [7:0] op);
        wr(2, op);
        wr(2, 8'(h * 4 + d));
        wr(2, c);
        trk[d] = c;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] e [8];
        for (int d = 0; d < 4; d++) trk[d] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: held after reset
        chk("R2 irq held", {7'b0, irq_o}, 8'h00);
        peek(1, v); chk("R2 msr held", v, 8'h00);
        peek(0, v); chk("R1 dor reset", v, 8'h00);
        wr(2, 8'h08);   // ignored while held (R2)

        // R3: release
        wr(0, 8'h1C);
        chk("R3 irq", {7'b0, irq_o}, 8'h01);
        peek(1, v); chk("R3 msr / R2 write ignored", v, 8'h80);
        chk("R1 motor", {4'b0, motor_on}, 8'h01);
        chk("R1 dma", {7'b0, dma_on}, 8'h01);

        // R8: data read without results
        rd(2, v); chk("R8 empty read", v, 8'h80);
        peek(1, v); chk("R8 msr unchanged", v, 8'h80);

        // R3 / R6: drain not-ready pends
        for (int d = 0; d < 4; d++) begin e[2*d] = 8'hC0 | 8'(d); e[2*d+1] = 8'h00; end
        sense("R3 R6 drain", 8, e);

        // R6: nothing pending
        e[0] = 8'h80;
        sense("R6 none", 1, e);

        // R1: DOR sweep
        for (int i = 0; i < 16; i++) begin
            logic [7:0] dv;
            dv = {4'(i), 1'(i % 2), 1'b1, 2'(i / 4)};
            wr(0, dv);
            peek(0, v); chk("R1 readback", v, dv);
            chk("R1 motor", {4'b0, motor_on}, {4'b0, 4'(i)});
            chk("R1 dma", {7'b0, dma_on}, {7'b0, 1'(i % 2)});
            chk("R1 sel", {6'b0, drv_sel}, {6'b0, 2'(i / 4)});
        end

        // R4 sweep with R10 high opcode bits
        for (int d = 0; d < 4; d++)
            for (int h = 0; h < 2; h++)
                for (int k = 0; k < 5; k++) begin
                    logic [7:0] c;
                    logic [7:0] op;
                    c  = (k == 0) ? 8'd0 : (k == 1) ? 8'd1 : (k == 2) ? 8'd39 : (k == 3) ? 8'd80 : 8'd255;
                    op = 8'h0F | 8'((k % 4) << 5);
                    wr(2, op);
                    peek(1, v); chk("R7 msr params", v, 8'h90);
                    wr(2, 8'(h * 4 + d));
                    wr(2, c);
                    trk[d] = c;
                    chk("R4 irq", {7'b0, irq_o}, 8'h01);
                    peek(1, v); chk("R4 no results", v, 8'h80);
                    e[0] = 8'h20 | 8'(h * 4 + d); e[1] = c;
                    sense("R4 seek", 2, e);
                end

        // R6: two pending, ascending order
        seek(3, 0, 8'd50, 8'h0F);
        seek(1, 1, 8'd7, 8'h0F);
        e[0] = 8'h25; e[1] = 8'd7; e[2] = 8'h23; e[3] = 8'd50;
        sense("R6 order", 4, e);

        // R5: recalibrate every drive
        for (int d = 0; d < 4; d++) begin
            wr(2, 8'h07); wr(2, 8'(d));
            trk[d] = 8'h00;
            chk("R5 irq", {7'b0, irq_o}, 8'h01);
            e[0] = 8'h20 | 8'(d); e[1] = 8'h00;
            sense("R5 recal", 2, e);
        end

        // R9: specify
        wr(2, 8'h03); wr(2, 8'hAF); wr(2, 8'h02);
        chk("R9 cfg_a", cfg_a, 8'hAF);
        chk("R9 cfg_b", cfg_b, 8'h02);
        peek(1, v); chk("R9 no results", v, 8'h80);
        chk("R9 irq", {7'b0, irq_o}, 8'h00);

        // R10: invalid opcode sweep
        for (int op = 0; op < 32; op++) begin
            if (op != 3 && op != 7 && op != 8 && op != 15) begin
                wr(2, 8'(op) | 8'((op % 8) << 5));
                peek(1, v); chk("R10 msr", v, 8'hD0);
                rd(2, v); chk("R10 byte", v, 8'h80);
                peek(1, v); chk("R10 msr after", v, 8'h80);
            end
        end

        // R11: writes during results ignored
        seek(0, 0, 8'd9, 8'h0F);
        wr(2, 8'h08);
        wr(2, 8'h0F);
        rd(2, v); chk("R11 byte0", v, 8'h20);
        rd(2, v); chk("R11 byte1", v, 8'd9);
        peek(1, v); chk("R11 msr", v, 8'h80);

        // R2 / R3: hold while pending, tracks kept
        seek(2, 0, 8'd33, 8'h0F);
        wr(0, 8'h18);
        chk("R2 irq dropped", {7'b0, irq_o}, 8'h00);
        peek(1, v); chk("R2 msr", v, 8'h00);
        wr(0, 8'h1C);
        chk("R3 irq again", {7'b0, irq_o}, 8'h01);
        for (int d = 0; d < 4; d++) begin e[2*d] = 8'hC0 | 8'(d); e[2*d+1] = trk[d]; end
        sense("R3 re-arm", 8, e);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule